// File: doc/BRIEF.md
# Front-End Synch and Header-Only Formatter

This block is the last stage of a detector front end before its serial uplink. On every bunch clock it receives the decoded fast-control command bits for that crossing together with an optional input data word, and it produces exactly one output frame. Every frame starts with a header made of a 4-bit frame type and the 12-bit bunch ID taken from a free-running bunch counter. The payload is one of three things: the oldest word of a small event buffer (data frame), nothing (header-only frame), or a word of a programmable synch pattern (synch frame).

The bunch counter is cleared only by the bunch-counter reset command and otherwise wraps once per orbit. The front-end reset command empties the event buffer and returns the controller to its running state, but leaves the bunch counter alone. The header-only and bunch-veto commands are merged: either one suppresses the payload and leaves the buffer untouched. A synch command empties the buffer and sends a pattern of 1 to 16 frames whose words come from a 16-entry register file. Since the counter and the command response have a fixed latency, every front end sends the pattern for the same bunch IDs. If a word arrives while the buffer is full and nothing leaves it, a sticky error flag is raised and only header-only frames go out until the next synch or front-end reset.

The controller has three states. RUN emits data or header-only frames. SYNC emits the remaining pattern words. HOLD emits header-only frames after an overflow. Transitions: any state goes to RUN on a front-end reset. Any state goes to SYNC on a synch command whose length is above one, or to RUN when the length is one. RUN goes to HOLD on overflow. SYNC goes to RUN (or to HOLD if an overflow occurred) after its last word.

Top module: `fe_frame_shaper`

## Requirements
- R1: While reset is held and immediately after its release, `frame_o` is all zeros and `err_o` is low; the first frame after release carries bunch ID 0.
- R2: Frame bits [27:16] carry the bunch counter value of the cycle the frame was built in; the counter advances by one every cycle and goes from ORBIT_LEN-1 back to 0.
- R3: A bunch-counter reset in cycle t does not change the bunch ID of the frame built in cycle t; the frame built in cycle t+1 carries bunch ID 0.
- R4: A front-end reset gives a header-only frame (type 2, payload 0) for its cycle, empties the buffer, clears `err_o` and leaves the bunch counter sequence unchanged. It takes priority over a synch command in the same cycle, so no pattern is sent.
- R5: In RUN, with neither header-only nor veto set and the buffer not empty, the frame has type 1 and payload bits [15:0] equal to the oldest buffered word. Words leave the buffer in arrival order. A word written in cycle t is sent in cycle t+1 at the earliest.
- R6: With the header-only bit or the veto bit set (either alone), the frame has type 2 and payload 0, and no word leaves the buffer.
- R7: In RUN with an empty buffer, the frame is header-only (type 2, payload 0).
- R8: A synch command in cycle t produces L = `sync_len_m1`+1 consecutive frames of type 4 in cycles t..t+L-1. Frame k carries pattern register k in bits [15:0] and the running bunch ID in its header.
- R9: A synch command discards every word in the buffer, including any word offered in the synch cycle itself. Once the pattern ends, frames are header-only until new data arrive.
- R10: A word offered while the buffer is full and no word leaves it raises `err_o` from the next sample on. From then on every frame is header-only even when no header-only command is present, until a synch or front-end reset clears `err_o`.
- R11: Pattern lengths of 1 frame (`sync_len_m1`=0) and 16 frames (`sync_len_m1`=15) are both produced exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_bxrst | input | 1 | Bunch-counter reset command |
| cmd_fersrt | input | 1 | Front-end data-path reset command (one cycle) |
| cmd_hdr | input | 1 | Header-only command |
| cmd_veto | input | 1 | Bunch veto command (merged with header-only) |
| cmd_sync | input | 1 | Synch command |
| din_valid | input | 1 | Input data word present |
| din | input | PAY_W | Input data word |
| pat_we | input | 1 | Pattern register write strobe |
| pat_addr | input | PIDX_W | Pattern register index |
| pat_wdata | input | PAY_W | Pattern register write data |
| sync_len_m1 | input | PIDX_W | Pattern length minus one |
| frame_o | output | FRAME_W | Frame: [31:28] type (1 data, 2 header-only, 4 synch), [27:16] bunch ID, [15:0] payload |
| err_o | output | 1 | Sticky buffer-overflow flag |

## Verification
Every result of the block appears one clock edge after the cycle that caused it. The frame for cycle t and the error flag are registered at the edge that ends cycle t. A bunch-counter reset shows up one frame later, because the frame at that edge still uses the old count. A buffered word can leave at the edge after it was written. The bench drives each cycle's inputs one time unit after a rising edge and compares the outputs one time unit after the next rising edge. A reference bunch counter in the bench gives the expected header of every frame.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

    localparam int TYPE_W = 4;

    typedef enum logic [TYPE_W-1:0] {
        FT_NONE = 4'h0,
        FT_DATA = 4'h1,
        FT_HDR  = 4'h2,
        FT_SYNC = 4'h4
    } frame_type_e;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_SYNC = 2'd1,
        ST_HOLD = 2'd2
    } fsf_state_e;

endpackage

// File: rtl/fsf_bx_counter.sv
module fsf_bx_counter #(
    parameter int BX_W      = 12,
    parameter int ORBIT_LEN = 3564
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic [BX_W-1:0] bx_o
);
    localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bx_o <= '0;
        end else if (clr || bx_o == LAST) begin
            bx_o <= '0;
        end else begin
            bx_o <= bx_o + 1'b1;
        end
    end
endmodule

// File: rtl/fsf_event_fifo.sv
module fsf_event_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wr_ptr;
    logic [AW:0]  rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rdata = mem[rd_ptr[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr[AW-1:0]] <= wdata;
        end
    end
endmodule

// File: rtl/fsf_sync_patterns.sv
module fsf_sync_patterns #(
    parameter int W = 16,
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (we && waddr == IW'(i)) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rdata = regs[raddr];
endmodule

// File: rtl/fsf_frame_ctrl.sv
module fsf_frame_ctrl
    import fsf_pkg::*;
#(
    parameter int PIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fersrt,
    input  logic              cmd_sync,
    input  logic              cmd_idle,
    input  logic              din_valid,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [PIDX_W-1:0] len_m1,
    output logic              fifo_flush,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic [PIDX_W-1:0] pat_idx,
    output frame_type_e       ftype,
    output logic              err_o
);
    fsf_state_e        state_q;
    fsf_state_e        state_d;
    logic [PIDX_W-1:0] idx_q;
    logic [PIDX_W-1:0] len_q;
    logic              ovfl;

    // State register together with the pattern index, latched length and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            idx_q   <= '0;
            len_q   <= '0;
            err_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cmd_fersrt) begin
                idx_q <= '0;
                err_o <= 1'b0;
            end else if (cmd_sync) begin
                idx_q <= PIDX_W'(1);
                len_q <= len_m1;
                err_o <= 1'b0;
            end else begin
                if (state_q == ST_SYNC) idx_q <= idx_q + 1'b1;
                if (ovfl)               err_o <= 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (cmd_fersrt) begin
            state_d = ST_RUN;
        end else if (cmd_sync) begin
            state_d = (len_m1 == '0) ? ST_RUN : ST_SYNC;
        end else begin
            unique case (state_q)
                ST_RUN:  if (ovfl) state_d = ST_HOLD;
                ST_SYNC: if (idx_q == len_q) state_d = (err_o || ovfl) ? ST_HOLD : ST_RUN;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_RUN;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fifo_flush = 1'b0;
        fifo_push  = 1'b0;
        fifo_pop   = 1'b0;
        ovfl       = 1'b0;
        pat_idx    = idx_q;
        ftype      = FT_HDR;
        if (cmd_fersrt) begin
            fifo_flush = 1'b1;
        end else if (cmd_sync) begin
            fifo_flush = 1'b1;
            pat_idx    = '0;
            ftype      = FT_SYNC;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    fifo_pop  = !cmd_idle && !fifo_empty;
                    ftype     = fifo_pop ? FT_DATA : FT_HDR;
                    fifo_push = din_valid && (!fifo_full || fifo_pop);
                    ovfl      = din_valid && fifo_full && !fifo_pop;
                end
                ST_SYNC: begin
                    ftype     = FT_SYNC;
                    fifo_push = din_valid && !fifo_full;
                    ovfl      = din_valid && fifo_full;
                end
                ST_HOLD: begin
                    ftype = FT_HDR;
                end
                default: begin
                    ftype = FT_HDR;
                end
            endcase
        end
    end
endmodule

// File: rtl/fe_frame_shaper.sv
module fe_frame_shaper
    import fsf_pkg::*;
#(
    parameter int BX_W      = 12,
    parameter int ORBIT_LEN = 3564,
    parameter int PAY_W     = 16,
    parameter int BUF_DEPTH = 8,
    parameter int PAT_DEPTH = 16,
    localparam int PIDX_W   = $clog2(PAT_DEPTH),
    localparam int FRAME_W  = TYPE_W + BX_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_bxrst,
    input  logic               cmd_fersrt,
    input  logic               cmd_hdr,
    input  logic               cmd_veto,
    input  logic               cmd_sync,
    input  logic               din_valid,
    input  logic [PAY_W-1:0]   din,
    input  logic               pat_we,
    input  logic [PIDX_W-1:0]  pat_addr,
    input  logic [PAY_W-1:0]   pat_wdata,
    input  logic [PIDX_W-1:0]  sync_len_m1,
    output logic [FRAME_W-1:0] frame_o,
    output logic               err_o
);
    logic [BX_W-1:0]   bx_cnt;
    logic              fifo_flush;
    logic              fifo_push;
    logic              fifo_pop;
    logic              fifo_full;
    logic              fifo_empty;
    logic [PAY_W-1:0]  fifo_rdata;
    logic [PIDX_W-1:0] pat_idx;
    logic [PAY_W-1:0]  pat_rdata;
    frame_type_e       ftype;
    logic [PAY_W-1:0]  payload;

    fsf_bx_counter #(.BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN)) u_bx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cmd_bxrst),
        .bx_o  (bx_cnt)
    );

    fsf_event_fifo #(.W(PAY_W), .DEPTH(BUF_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fifo_flush),
        .push  (fifo_push),
        .wdata (din),
        .pop   (fifo_pop),
        .rdata (fifo_rdata),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    fsf_sync_patterns #(.W(PAY_W), .N(PAT_DEPTH)) u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pat_we),
        .waddr (pat_addr),
        .wdata (pat_wdata),
        .raddr (pat_idx),
        .rdata (pat_rdata)
    );

    fsf_frame_ctrl #(.PIDX_W(PIDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_fersrt (cmd_fersrt),
        .cmd_sync   (cmd_sync),
        .cmd_idle   (cmd_hdr || cmd_veto),
        .din_valid  (din_valid),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .len_m1     (sync_len_m1),
        .fifo_flush (fifo_flush),
        .fifo_push  (fifo_push),
        .fifo_pop   (fifo_pop),
        .pat_idx    (pat_idx),
        .ftype      (ftype),
        .err_o      (err_o)
    );

    always_comb begin
        unique case (ftype)
            FT_SYNC: payload = pat_rdata;
            FT_DATA: payload = fifo_rdata;
            default: payload = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o <= '0;
        end else begin
            frame_o <= {ftype, bx_cnt, payload};
        end
    end
endmodule

// File: rtl/fsf_checker.sv
module fsf_checker #(
    parameter int BX_W      = 12,
    parameter int ORBIT_LEN = 3564,
    parameter int FRAME_W   = 32,
    parameter int PAY_W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_bxrst,
    input logic               cmd_fersrt,
    input logic               cmd_sync,
    input logic [FRAME_W-1:0] frame_o,
    input logic               err_o,
    input logic [BX_W-1:0]    bx_q,
    input logic               flush,
    input logic               fifo_empty
);
    localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

    logic [3:0] ftype;
    assign ftype = frame_o[FRAME_W-1 -: 4];

    p_bx_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_bxrst |=> (bx_q == '0));

    p_fersrt_keeps_bx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fersrt && !cmd_bxrst) |=>
            (bx_q == (($past(bx_q) == LAST) ? '0 : $past(bx_q) + 1'b1)));

    p_hdr_no_payload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ftype == 4'h2) |-> (frame_o[PAY_W-1:0] == '0));

    p_sync_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sync && !cmd_fersrt) |=> (ftype == 4'h4));

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fifo_empty);

    p_err_no_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (ftype != 4'h1));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !cmd_sync && !cmd_fersrt) |=> err_o);
endmodule

bind fe_frame_shaper fsf_checker #(
    .BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN), .FRAME_W(FRAME_W), .PAY_W(PAY_W)
) u_fsf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_bxrst  (cmd_bxrst),
    .cmd_fersrt (cmd_fersrt),
    .cmd_sync   (cmd_sync),
    .frame_o    (frame_o),
    .err_o      (err_o),
    .bx_q       (bx_cnt),
    .flush      (fifo_flush),
    .fifo_empty (fifo_empty)
);

// File: tb/fe_frame_shaper_bench.sv
module fe_frame_shaper_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BX_W       = 12;
    localparam int ORBIT_LEN  = 20;
    localparam int PAY_W      = 16;
    localparam int BUF_DEPTH  = 4;
    localparam int FRAME_W    = 4 + BX_W + PAY_W;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cmd_bxrst, cmd_fersrt, cmd_hdr, cmd_veto, cmd_sync;
    logic             din_valid;
    logic [PAY_W-1:0] din;
    logic             pat_we;
    logic [3:0]       pat_addr;
    logic [PAY_W-1:0] pat_wdata;
    logic [3:0]       sync_len_m1;
    logic [FRAME_W-1:0] frame_o;
    logic             err_o;

    int checks = 0;
    int fails  = 0;
    int exp_bx = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_frame_shaper #(
        .BX_W(BX_W), .ORBIT_LEN(ORBIT_LEN), .PAY_W(PAY_W),
        .BUF_DEPTH(BUF_DEPTH), .PAT_DEPTH(16)
    ) u_fe_frame_shaper (
        .clk(clk), .rst_n(rst_n), .cmd_bxrst(cmd_bxrst), .cmd_fersrt(cmd_fersrt),
        .cmd_hdr(cmd_hdr), .cmd_veto(cmd_veto), .cmd_sync(cmd_sync),
        .din_valid(din_valid), .din(din), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .sync_len_m1(sync_len_m1),
        .frame_o(frame_o), .err_o(err_o)
    );

    function automatic logic [15:0] pat_word(int i);
        return {8'hC3, 4'(i), ~4'(i)};
    endfunction

    task automatic expect_eq(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_inputs();
        cmd_bxrst = 0; cmd_fersrt = 0; cmd_hdr = 0; cmd_veto = 0; cmd_sync = 0;
        din_valid = 0; din = '0; pat_we = 0;
    endtask

    // One bunch clock; checks the header bunch ID against the bench reference (R2)
    task automatic tick();
        int pre_bx;
        pre_bx = exp_bx;
        @(posedge clk);
        #1;
        expect_eq("R2 bunch id", 32'(frame_o[27:16]), 32'(pre_bx));
        if (cmd_bxrst) exp_bx = 0;
        else exp_bx = (exp_bx == ORBIT_LEN-1) ? 0 : exp_bx + 1;
        clear_inputs();
    endtask

    task automatic check_frame(string req, logic [3:0] ft, logic [15:0] pay);
        expect_eq({req, " type"}, 32'(frame_o[31:28]), 32'(ft));
        expect_eq({req, " payload"}, 32'(frame_o[15:0]), 32'(pay));
    endtask

    task automatic push_held(logic [15:0] w);
        din_valid = 1; din = w; cmd_hdr = 1;
        tick();
        check_frame("R6 held push", 4'h2, 16'h0);
    endtask

    task automatic t_reset();
        expect_eq("R1 frame at reset", 32'(frame_o), 32'h0);
        expect_eq("R1 err at reset", 32'(err_o), 32'h0);
    endtask

    task automatic t_count_wrap();
        for (int i = 0; i < 25; i++) begin
            tick();
            check_frame("R7 empty idle", 4'h2, 16'h0);
        end
    endtask

    task automatic t_bxrst();
        tick(); tick();
        cmd_bxrst = 1;
        tick();
        tick();
        expect_eq("R3 bunch id after reset", 32'(frame_o[27:16]), 32'h0);
        tick();
        expect_eq("R3 counting resumes", 32'(frame_o[27:16]), 32'h1);
    endtask

    task automatic t_data();
        push_held(16'hD001);
        push_held(16'hD002);
        din_valid = 1; din = 16'hD003; cmd_veto = 1;
        tick();
        check_frame("R6 veto alone", 4'h2, 16'h0);
        tick(); check_frame("R5 first", 4'h1, 16'hD001);
        tick(); check_frame("R5 second", 4'h1, 16'hD002);
        tick(); check_frame("R5 third", 4'h1, 16'hD003);
        tick(); check_frame("R7 drained", 4'h2, 16'h0);
        din_valid = 1; din = 16'hD004;
        tick(); check_frame("R5 not same cycle", 4'h2, 16'h0);
        tick(); check_frame("R5 next cycle", 4'h1, 16'hD004);
    endtask

    task automatic t_fersrt();
        push_held(16'hE001);
        push_held(16'hE002);
        cmd_fersrt = 1;
        tick(); check_frame("R4 reset frame", 4'h2, 16'h0);
        tick(); check_frame("R4 buffer emptied", 4'h2, 16'h0);
        push_held(16'hE003);
        cmd_fersrt = 1; cmd_sync = 1; sync_len_m1 = 4'd3;
        tick(); check_frame("R4 priority over synch", 4'h2, 16'h0);
        tick(); check_frame("R4 no pattern", 4'h2, 16'h0);
    endtask

    task automatic t_sync(int len, string req);
        push_held(16'hF001);
        push_held(16'hF002);
        cmd_sync = 1; sync_len_m1 = 4'(len - 1); din_valid = 1; din = 16'hF003;
        for (int k = 0; k < len; k++) begin
            tick();
            check_frame(req, 4'h4, pat_word(k));
        end
        tick(); check_frame("R9 buffer flushed", 4'h2, 16'h0);
        tick(); check_frame("R9 still empty", 4'h2, 16'h0);
    endtask

    task automatic fill_and_overflow();
        for (int i = 0; i < BUF_DEPTH; i++) push_held(16'hB000 + 16'(i));
        expect_eq("R10 no error when just full", 32'(err_o), 32'h0);
        push_held(16'hBFFF);
        expect_eq("R10 error raised", 32'(err_o), 32'h1);
        for (int i = 0; i < 3; i++) begin
            tick();
            check_frame("R10 forced header only", 4'h2, 16'h0);
            expect_eq("R10 error sticky", 32'(err_o), 32'h1);
        end
    endtask

    task automatic t_overflow();
        fill_and_overflow();
        cmd_sync = 1; sync_len_m1 = 4'd0;
        tick();
        check_frame("R10 synch clears", 4'h4, pat_word(0));
        expect_eq("R10 err cleared by synch", 32'(err_o), 32'h0);
        tick(); check_frame("R10 empty after synch", 4'h2, 16'h0);
        fill_and_overflow();
        cmd_fersrt = 1;
        tick();
        expect_eq("R4 err cleared by FE reset", 32'(err_o), 32'h0);
        din_valid = 1; din = 16'hA5A5;
        tick(); check_frame("R10 running again", 4'h2, 16'h0);
        tick(); check_frame("R10 data after clear", 4'h1, 16'hA5A5);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_inputs();
        pat_addr = '0; pat_wdata = '0; sync_len_m1 = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1;
        exp_bx = 0;
        tick();
        expect_eq("R1 first id", 32'(frame_o[27:16]), 32'h0);
        for (int i = 0; i < 16; i++) begin
            pat_we = 1; pat_addr = 4'(i); pat_wdata = pat_word(i);
            tick();
        end
        t_count_wrap();
        t_bxrst();
        t_data();
        t_fersrt();
        t_sync(5, "R8 pattern");
        t_sync(1, "R11 length one");
        t_sync(16, "R11 length sixteen");
        t_overflow();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule